// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the internal address stream for a pipelined synchronous memory that runs four-beat bursts. On a rising clock edge where an address strobe is honoured, it registers the external address, the three chip-enable inputs and the burst-order select. From then on the two low address bits come from an internal beat counter instead of the external bus. The counter moves one beat on each clock edge where the advance input is low. The upper address bits stay at their captured value until the next strobe.

There are two strobes, and they are qualified differently. The controller strobe is always honoured. The processor strobe is honoured only when the primary chip enable is active at the same edge. The order select picks one of two burst orders. Linear order counts the low bits up modulo four from the starting value. Interleaved order XORs the starting low bits with a beat index that counts 0, 1, 2, 3. The outputs are register-driven and never depend combinationally on the inputs. The captured address therefore appears in the cycle after the strobe edge. Each later beat follows one clock after the one before it.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted, and after it is released before any strobe, `addr_out` is all zeros and `addr_valid` is 0.
- R2: A clock edge with `ads_ctrl_n` low captures `addr_in`, whatever the chip enables are. `addr_out` equals that address from the next cycle on.
- R3: A clock edge with `ads_proc_n` low and `ads_ctrl_n` high captures `addr_in` only if `ce_pri_n` is low at that edge. Otherwise the strobe is ignored and `addr_out` and `addr_valid` stay unchanged.
- R4: After a capture, `addr_valid` is 1 exactly when, at the capture edge, `ce_pri_n` was low, `ce_sec` was high and `ce_ter_n` was low.
- R5: On an edge with no honoured strobe, `adv_n` low and `addr_valid` 1, the burst moves forward exactly one beat.
- R6: On an edge with no honoured strobe and `adv_n` high, `addr_out` and `addr_valid` hold.
- R7: With `order_sel`=0 (linear) captured, the low two bits of `addr_out` at beat k are (start + k) mod 4. Example: a start of 01 gives 01, 10, 11, 00.
- R8: With `order_sel`=1 (interleaved) captured, the low two bits at beat k are start XOR k. Example: a start of 10 gives 10, 11, 00, 01.
- R9: The upper address bits (all bits above bit 1) do not change between strobes. After the fourth beat the sequence wraps back to the starting address.
- R10: A honoured strobe during a burst restarts at beat 0 from the newly captured address. A strobe takes priority over a simultaneous advance.
- R11: `order_sel` is sampled only at a capture edge. Changing it in the middle of a burst does not alter that burst's order.
- R12: While `addr_valid` is 0, `adv_n` low has no effect on `addr_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| addr_in | input | ADDR_W | External starting address |
| ads_proc_n | input | 1 | Processor address strobe, active low, gated by `ce_pri_n` |
| ads_ctrl_n | input | 1 | Controller address strobe, active low, always honoured |
| adv_n | input | 1 | Burst advance, active low |
| ce_pri_n | input | 1 | Primary chip enable, active low |
| ce_sec | input | 1 | Secondary chip enable, active high |
| ce_ter_n | input | 1 | Tertiary chip enable, active low |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_out | output | ADDR_W | Current internal address |
| addr_valid | output | 1 | Device selected for the current burst |

## Verification
A wrong beat index or wrong stored mode shows up in the low two bits of `addr_out` one cycle after the advance edge that should have moved it. A wrong stored base or a missed capture shows in the upper bits one cycle after the strobe edge. A wrong select flag shows in `addr_valid` at the same point, and also through advances that should have been ignored. Because of this, a reference model compared on every clock catches any divergence in the cycle right after the edge that caused it. Directed bursts check both orders from non-zero starting bits, the wrap after four beats, the gated processor strobe, a restart in mid-burst and a mode change in mid-burst.

// File: rtl/bas_pkg.sv
package bas_pkg;

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } burst_order_e;

endpackage

// File: rtl/bas_strobe_qual.sv
module bas_strobe_qual (
  input  logic ads_proc_n,
  input  logic ads_ctrl_n,
  input  logic ce_pri_n,
  input  logic ce_sec,
  input  logic ce_ter_n,
  output logic load,
  output logic chip_sel
);

  logic proc_ok;
  logic ctrl_ok;

  always_comb begin
    // processor strobe needs the primary enable; controller strobe always counts
    proc_ok  = ~ads_proc_n & ~ce_pri_n;
    ctrl_ok  = ~ads_ctrl_n;
    load     = proc_ok | ctrl_ok;
    chip_sel = ~ce_pri_n & ce_sec & ~ce_ter_n;
  end

endmodule

// File: rtl/bas_capture.sv
module bas_capture
  import bas_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              order_sel,
  input  logic              chip_sel,
  output logic [ADDR_W-1:0] base_q,
  output burst_order_e      mode_q,
  output logic              valid_q
);

  logic [ADDR_W-1:0] base_d;
  burst_order_e      mode_d;
  logic              valid_d;

  always_comb begin
    base_d  = base_q;
    mode_d  = mode_q;
    valid_d = valid_q;
    if (load) begin
      base_d  = addr_in;
      mode_d  = burst_order_e'(order_sel);
      valid_d = chip_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      mode_q  <= ORDER_LINEAR;
      valid_q <= 1'b0;
    end else if (load) begin
      base_q  <= base_d;
      mode_q  <= mode_d;
      valid_q <= valid_d;
    end
  end

endmodule

// File: rtl/bas_beat_counter.sv
module bas_beat_counter #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  output logic [BEAT_W-1:0] beat_q
);

  logic [BEAT_W-1:0] beat_d;
  logic              beat_en;

  always_comb begin
    beat_en = load | step;
    if (load) beat_d = '0;
    else      beat_d = beat_q + BEAT_W'(1);   // wraps modulo the burst length
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beat_q <= '0;
    else if (beat_en) beat_q <= beat_d;
  end

endmodule

// File: rtl/bas_order_map.sv
module bas_order_map
  import bas_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  burst_order_e      mode,
  input  logic [BEAT_W-1:0] start_low,
  input  logic [BEAT_W-1:0] beat,
  output logic [BEAT_W-1:0] low_out
);

  logic [BEAT_W-1:0] lin_low;
  logic [BEAT_W-1:0] ilv_low;

  assign lin_low = start_low + beat;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv_bit
    assign ilv_low[b] = start_low[b] ^ beat[b];
  end

  always_comb begin
    unique case (mode)
      ORDER_INTERLEAVE: low_out = ilv_low;
      default:          low_out = lin_low;
    endcase
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              ads_proc_n,
  input  logic              ads_ctrl_n,
  input  logic              adv_n,
  input  logic              ce_pri_n,
  input  logic              ce_sec,
  input  logic              ce_ter_n,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] addr_out,
  output logic              addr_valid
);

  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic              load;
  logic              chip_sel;
  logic              step;
  logic [ADDR_W-1:0] base_q;
  burst_order_e      mode_q;
  logic              valid_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] low_addr;
  logic [UPPER_W-1:0] upper_addr;

  bas_strobe_qual u_qual (
    .ads_proc_n (ads_proc_n),
    .ads_ctrl_n (ads_ctrl_n),
    .ce_pri_n   (ce_pri_n),
    .ce_sec     (ce_sec),
    .ce_ter_n   (ce_ter_n),
    .load       (load),
    .chip_sel   (chip_sel)
  );

  bas_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .addr_in   (addr_in),
    .order_sel (order_sel),
    .chip_sel  (chip_sel),
    .base_q    (base_q),
    .mode_q    (mode_q),
    .valid_q   (valid_q)
  );

  // a strobe outranks advance; advance only while the device is selected
  assign step = ~load & ~adv_n & valid_q;

  bas_beat_counter #(.BEAT_W(BEAT_W)) u_beat (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .step   (step),
    .beat_q (beat_q)
  );

  bas_order_map #(.BEAT_W(BEAT_W)) u_map (
    .mode      (mode_q),
    .start_low (base_q[BEAT_W-1:0]),
    .beat      (beat_q),
    .low_out   (low_addr)
  );

  assign upper_addr = base_q[ADDR_W-1:BEAT_W];
  assign addr_out   = {upper_addr, low_addr};
  assign addr_valid = valid_q;

endmodule

// File: rtl/bas_checker.sv
module bas_checker #(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic              ads_proc_n,
  input logic              ads_ctrl_n,
  input logic              adv_n,
  input logic              ce_pri_n,
  input logic              ce_sec,
  input logic              ce_ter_n,
  input logic [ADDR_W-1:0] addr_out,
  input logic              addr_valid,
  input logic              mode_bit
);

  logic honoured;
  logic sel_now;
  assign honoured = ~ads_ctrl_n | (~ads_proc_n & ~ce_pri_n);
  assign sel_now  = ~ce_pri_n & ce_sec & ~ce_ter_n;

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_idle_R1: assert (!addr_valid && addr_out == '0)
        else $error("reset state wrong");
    end
  end

  assert_ctrl_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ads_ctrl_n |=> addr_out == $past(addr_in));

  assert_proc_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ads_ctrl_n && !ads_proc_n && ce_pri_n && adv_n) |=>
      ($stable(addr_out) && $stable(addr_valid)));

  assert_valid_from_enables_R4: assert property (@(posedge clk) disable iff (!rst_n)
    honoured |=> addr_valid == $past(sel_now));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!honoured && adv_n) |=> ($stable(addr_out) && $stable(addr_valid)));

  assert_linear_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!honoured && !adv_n && addr_valid && !mode_bit) |=>
      addr_out[BEAT_W-1:0] == BEAT_W'($past(addr_out[BEAT_W-1:0]) + 1));

  assert_interleave_moves_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!honoured && !adv_n && addr_valid && mode_bit) |=>
      $countones(addr_out[BEAT_W-1:0] ^ $past(addr_out[BEAT_W-1:0])) != 0);

  assert_upper_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !honoured |=> $stable(addr_out[ADDR_W-1:BEAT_W]));

  assert_idle_advance_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!honoured && !addr_valid) |=> $stable(addr_out));

endmodule

bind burst_addr_seq bas_checker #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr_in    (addr_in),
  .ads_proc_n (ads_proc_n),
  .ads_ctrl_n (ads_ctrl_n),
  .adv_n      (adv_n),
  .ce_pri_n   (ce_pri_n),
  .ce_sec     (ce_sec),
  .ce_ter_n   (ce_ter_n),
  .addr_out   (addr_out),
  .addr_valid (addr_valid),
  .mode_bit   (mode_q)
);

// File: tb/sim_burst_addr_seq.sv
`timescale 1ns/1ps
module sim_burst_addr_seq;

  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          ads_proc_n = 1'b1, ads_ctrl_n = 1'b1, adv_n = 1'b1;
  logic          ce_pri_n = 1'b0, ce_sec = 1'b1, ce_ter_n = 1'b0, order_sel = 1'b0;
  logic [AW-1:0] addr_out;
  logic          addr_valid;

  int    checks = 0;
  int    failures = 0;
  bit    done = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BEAT_W(2)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .ads_proc_n(ads_proc_n),
    .ads_ctrl_n(ads_ctrl_n), .adv_n(adv_n), .ce_pri_n(ce_pri_n), .ce_sec(ce_sec),
    .ce_ter_n(ce_ter_n), .order_sel(order_sel), .addr_out(addr_out),
    .addr_valid(addr_valid)
  );

  // behavioural reference model
  logic [AW-1:0] m_base;
  int            m_beat;
  bit            m_ilv, m_valid;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_base = '0; m_beat = 0; m_ilv = 0; m_valid = 0;
    end else begin
      bit take;
      take = (ads_ctrl_n == 1'b0) || (ads_proc_n == 1'b0 && ce_pri_n == 1'b0);
      if (take) begin
        m_base  = addr_in;
        m_beat  = 0;
        m_ilv   = order_sel;
        m_valid = (ce_pri_n == 1'b0) && (ce_sec == 1'b1) && (ce_ter_n == 1'b0);
      end else if (adv_n == 1'b0 && m_valid) begin
        m_beat = (m_beat + 1) % 4;
      end
    end
  end

  function automatic logic [AW-1:0] model_addr();
    int lo;
    int s;
    s  = int'(m_base[1:0]);
    lo = m_ilv ? (s ^ m_beat) : ((s + m_beat) % 4);
    return {m_base[AW-1:2], 2'(lo)};
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (addr_out !== model_addr() || addr_valid !== m_valid) begin
        failures++;
        $display("FAIL %s model: addr=%h valid=%b expected addr=%h valid=%b",
                 cur_req, addr_out, addr_valid, model_addr(), m_valid);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_out(string req, logic [AW-1:0] ea, logic ev);
    checks++;
    if (addr_out !== ea || addr_valid !== ev) begin
      failures++;
      $display("FAIL %s: addr=%h valid=%b expected addr=%h valid=%b",
               req, addr_out, addr_valid, ea, ev);
    end
  endtask

  task automatic idle();
    ads_proc_n = 1'b1; ads_ctrl_n = 1'b1; adv_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    expect_out("R1", '0, 1'b0);
    rst_n = 1'b1;
    tick();
    expect_out("R1", '0, 1'b0);

    // controller strobe, linear, start low bits 01
    cur_req = "R2";
    addr_in = 20'h12345; ads_ctrl_n = 1'b0; order_sel = 1'b0;
    tick(); idle();
    expect_out("R2", 20'h12345, 1'b1);
    cur_req = "R7";
    adv_n = 1'b0;
    tick(); expect_out("R7", 20'h12346, 1'b1);
    tick(); expect_out("R7", 20'h12347, 1'b1);
    tick(); expect_out("R5", 20'h12344, 1'b1);
    tick(); expect_out("R9", 20'h12345, 1'b1);

    cur_req = "R6";
    adv_n = 1'b1;
    tick(); expect_out("R6", 20'h12345, 1'b1);

    // processor strobe with primary enable inactive: ignored
    cur_req = "R3";
    addr_in = 20'hABCDE; ads_proc_n = 1'b0; ce_pri_n = 1'b1;
    tick(); idle(); ce_pri_n = 1'b0;
    expect_out("R3", 20'h12345, 1'b1);

    // processor strobe honoured, interleaved, start low bits 10
    cur_req = "R8";
    ads_proc_n = 1'b0; order_sel = 1'b1;
    tick(); idle();
    expect_out("R3", 20'hABCDE, 1'b1);
    adv_n = 1'b0; order_sel = 1'b0;
    tick(); expect_out("R8", 20'hABCDF, 1'b1);
    cur_req = "R11";
    tick(); expect_out("R11", 20'hABCDC, 1'b1);
    tick(); expect_out("R8", 20'hABCDD, 1'b1);
    tick(); expect_out("R9", 20'hABCDE, 1'b1);

    // restart in mid-burst, strobe beats advance
    cur_req = "R10";
    tick(); expect_out("R10", 20'hABCDF, 1'b1);
    addr_in = 20'h00003; ads_ctrl_n = 1'b0;
    tick(); ads_ctrl_n = 1'b1;
    expect_out("R10", 20'h00003, 1'b1);
    tick(); expect_out("R10", 20'h00000, 1'b1);

    // deselected capture, then advance ignored
    cur_req = "R4";
    adv_n = 1'b1; ce_sec = 1'b0; addr_in = 20'h55551; ads_ctrl_n = 1'b0;
    tick(); idle(); ce_sec = 1'b1;
    expect_out("R4", 20'h55551, 1'b0);
    cur_req = "R12";
    adv_n = 1'b0;
    tick(); expect_out("R12", 20'h55551, 1'b0);
    tick(); expect_out("R12", 20'h55551, 1'b0);
    ce_ter_n = 1'b1; ads_ctrl_n = 1'b0; addr_in = 20'h0F0F2;
    tick(); idle(); ce_ter_n = 1'b0;
    expect_out("R4", 20'h0F0F2, 1'b0);

    // random traffic against the model
    cur_req = "R5";
    for (int i = 0; i < 400; i++) begin
      addr_in    = AW'($urandom);
      ads_ctrl_n = ($urandom % 7) != 0;
      ads_proc_n = ($urandom % 5) != 0;
      adv_n      = ($urandom % 3) == 0;
      ce_pri_n   = ($urandom % 6) == 0;
      ce_sec     = ($urandom % 8) != 0;
      ce_ter_n   = ($urandom % 8) == 0;
      order_sel  = $urandom % 2;
      tick();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule